// File: doc/BRIEF.md
# SPI EEPROM Word Write Sequencer

This block takes a request made of a first word index, a word count and a stream of 16-bit data words. It writes those words into a serial EEPROM over a four-wire SPI link, using mode 0 framing: the clock idles low and each bit is set up before the rising edge. The link is driven bit by bit by a small shift engine. The sequencer builds every command frame itself, splits the transfer at the device's page boundaries, and waits for the device to report that it is idle before it starts each page.

Every page goes through the same steps. First comes a status poll, in which a read-status frame is repeated until bit 0 of the returned byte is clear. Then a separate write-enable frame is sent. Last comes a write frame carrying the opcode, the byte address and the data words. Each of these steps begins with a short deselect pulse on chip select. A request that does not fit inside the device is refused at once. A device that stays busy for too many polls ends the request with an error. After the last page, chip select is held high for a settle interval, and then a done pulse is given.

Top module: `spi_eeprom_writer`

## Requirements
- R1: A start with first index >= WORD_SIZE, with a count of zero, or with a count greater than WORD_SIZE minus the first index gives a one-cycle `error` in the cycle after the start. No SPI frame is produced, and chip select stays high.
- R2: A status poll is a single frame. It sends opcode 0x05 as OP_BITS bits, MSB first, and then clocks in 8 status bits with MOSI held low. While status bit 0 (the last bit received) is 1, the poll is repeated in a new frame.
- R3: If POLL_LIMIT polls in a row all return a busy status, chip select goes high, `error` pulses, and no write-enable or write frame follows.
- R4: In every page, once the status is ready, the write-enable opcode 0x06 is sent alone in its own frame, before the write frame.
- R5: A write frame begins with opcode 0x02. This is followed by the byte address (twice the word index), sent as its low ADDR_BITS bits, MSB first.
- R6: When ADDR_BITS is 8 and the page's first word index is 128 or more, the write opcode is 0x0A, that is, 0x02 with bit 3 set.
- R7: Each data word is sent as 16 bits: bits 7..0 first, then bits 15..8, each byte MSB first.
- R8: A write frame ends after a word whose next byte address is a multiple of PAGE_BYTES. The remaining words then start a new page with a poll, a write enable and a write frame.
- R9: The SPI clock is low whenever chip select is high, and MOSI does not change while the clock is high.
- R10: After the last word, chip select goes high. `done` pulses no earlier than SETTLE_CLKS cycles later, while chip select is still high. `done` and `error` never pulse in the same cycle.
- R11: `wr_ready` is high only inside a write frame, when the next word is due. Words are consumed only on `wr_valid && wr_ready`, and in the order they are given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a request; ignored while busy |
| first_word | input | IDX_W | Word index of the first word to write |
| word_count | input | IDX_W | Number of words to write |
| wr_data | input | 16 | Data word offered |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Sequencer takes the word this cycle if valid |
| done | output | 1 | One-cycle pulse: request finished |
| error | output | 1 | One-cycle pulse: request refused or device timed out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to the device |
| spi_miso | input | 1 | Data from the device |

## Verification
A device model on the SPI pins captures every frame between chip-select edges and returns a programmable number of busy status bytes. A scoreboard compares each captured frame, bit for bit, with frames predicted from the request. A single-word write in the low half of the array checks the basic frame order and the byte swap. A write that crosses a page boundary shows whether the split happens at the correct word and whether the second page gets its own poll and write enable. A write in the upper half of an 8-bit-address device separates a correct opcode from one that lacks the high address bit. Busy-then-ready and busy-forever patterns separate polling from timing out, out-of-range requests must produce no traffic at all, and irregular gaps in `wr_valid` test that the handshake is honoured.

// File: rtl/spiwr_pkg.sv
package spiwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TOG_HI,
        ST_TOG_LO,
        ST_POLL_OP,
        ST_POLL_IN,
        ST_WREN,
        ST_WR_OP,
        ST_WR_ADDR,
        ST_WR_WAIT,
        ST_WR_DATA,
        ST_SETTLE
    } seq_state_e;

    localparam logic [7:0] OPC_STATUS  = 8'h05;
    localparam logic [7:0] OPC_WEN     = 8'h06;
    localparam logic [7:0] OPC_WRITE   = 8'h02;
    localparam logic [7:0] OPC_HI_ADDR = 8'h08;

    function automatic logic [15:0] swap_bytes(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/spiwr_shift.sv
module spiwr_shift #(
    parameter int HALF_CLKS = 2,
    parameter int MAX_BITS  = 16,
    parameter int BW        = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                send,
    input  logic [MAX_BITS-1:0] tx,
    input  logic [BW-1:0]       nbits,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic                fin,
    output logic [MAX_BITS-1:0] rx
);
    localparam int HW = $clog2(HALF_CLKS + 1);

    typedef struct packed {
        logic                active;
        logic                high;
        logic [HW-1:0]       tmr;
        logic [BW-1:0]       left;
        logic [MAX_BITS-1:0] sh;
        logic [MAX_BITS-1:0] rx;
        logic                send;
        logic                fin;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.high   = 1'b0;
                s_d.tmr    = '0;
                s_d.left   = nbits;
                s_d.sh     = tx << (BW'(MAX_BITS) - nbits);
                s_d.send   = send;
                s_d.rx     = '0;
            end
        end else if (s_q.tmr == HW'(HALF_CLKS - 1)) begin
            s_d.tmr = '0;
            if (!s_q.high) begin
                s_d.high = 1'b1;
            end else begin
                s_d.high = 1'b0;
                s_d.rx   = {s_q.rx[MAX_BITS-2:0], miso};
                s_d.sh   = s_q.sh << 1;
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == BW'(1)) begin
                    s_d.active = 1'b0;
                    s_d.fin    = 1'b1;
                end
            end
        end else begin
            s_d.tmr = s_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck  = s_q.active & s_q.high;
    assign mosi = s_q.active & s_q.send & s_q.sh[MAX_BITS-1];
    assign fin  = s_q.fin;
    assign rx   = s_q.rx;

    // R9
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spi_eeprom_writer.sv
module spi_eeprom_writer
    import spiwr_pkg::*;
#(
    parameter int WORD_SIZE   = 512,
    parameter int ADDR_BITS   = 8,
    parameter int OP_BITS     = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int HALF_CLKS   = 2,
    parameter int POLL_LIMIT  = 16,
    parameter int SETTLE_CLKS = 1000,
    parameter int IDX_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] first_word,
    input  logic [IDX_W-1:0] word_count,
    input  logic [15:0]      wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             done,
    output logic             error,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int SHW = 16;
    localparam int BW  = $clog2(SHW + 1);
    localparam int PW  = $clog2(POLL_LIMIT + 1);
    localparam int TW  = $clog2(SETTLE_CLKS + HALF_CLKS + 1);

    typedef struct packed {
        seq_state_e       st;
        seq_state_e       ret;
        logic             cs_n;
        logic [IDX_W-1:0] widx;
        logic [IDX_W-1:0] left;
        logic [PW-1:0]    polls;
        logic [TW-1:0]    tmr;
        logic [15:0]      word;
        logic             go;
        logic             send;
        logic [15:0]      tx;
        logic [BW-1:0]    nbits;
        logic             issued;
        logic             done;
        logic             error;
    } seq_t;

    seq_t r_d, r_q;

    logic            sh_fin;
    logic [SHW-1:0]  sh_rx;
    logic            bad_req;
    logic [IDX_W:0]  next_byte;
    logic [7:0]      wr_opc;

    assign bad_req = (32'(first_word) >= 32'(WORD_SIZE)) || (word_count == '0) ||
                     (32'(word_count) > (32'(WORD_SIZE) - 32'(first_word)));
    assign next_byte = {r_q.widx + 1'b1, 1'b0};
    assign wr_opc = OPC_WRITE |
        (((ADDR_BITS == 8) && (32'(r_q.widx) >= 32'd128)) ? OPC_HI_ADDR : 8'h00);

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.done  = 1'b0;
        r_d.error = 1'b0;
        case (r_q.st)
            ST_IDLE: if (start) begin
                if (bad_req) begin
                    r_d.error = 1'b1;
                end else begin
                    r_d.widx  = first_word;
                    r_d.left  = word_count;
                    r_d.polls = '0;
                    r_d.tmr   = '0;
                    r_d.ret   = ST_POLL_OP;
                    r_d.st    = ST_TOG_HI;
                end
            end
            ST_TOG_HI: begin
                r_d.cs_n = 1'b1;
                if (r_q.tmr == TW'(HALF_CLKS - 1)) begin
                    r_d.tmr = '0;
                    r_d.st  = ST_TOG_LO;
                end else r_d.tmr = r_q.tmr + 1'b1;
            end
            ST_TOG_LO: begin
                r_d.cs_n = 1'b0;
                if (r_q.tmr == TW'(HALF_CLKS - 1)) begin
                    r_d.tmr = '0;
                    r_d.st  = r_q.ret;
                end else r_d.tmr = r_q.tmr + 1'b1;
            end
            ST_POLL_OP, ST_WREN, ST_WR_OP, ST_WR_ADDR, ST_WR_DATA, ST_POLL_IN: begin
                if (!r_q.issued) begin
                    r_d.go     = 1'b1;
                    r_d.issued = 1'b1;
                    r_d.send   = (r_q.st != ST_POLL_IN);
                    case (r_q.st)
                        ST_POLL_OP: begin r_d.tx = 16'(OPC_STATUS); r_d.nbits = BW'(OP_BITS); end
                        ST_POLL_IN: begin r_d.tx = '0;              r_d.nbits = BW'(8); end
                        ST_WREN:    begin r_d.tx = 16'(OPC_WEN);    r_d.nbits = BW'(OP_BITS); end
                        ST_WR_OP:   begin r_d.tx = 16'(wr_opc);     r_d.nbits = BW'(OP_BITS); end
                        ST_WR_ADDR: begin r_d.tx = 16'({r_q.widx, 1'b0}); r_d.nbits = BW'(ADDR_BITS); end
                        default:    begin r_d.tx = r_q.word;        r_d.nbits = BW'(16); end
                    endcase
                end else if (sh_fin) begin
                    r_d.issued = 1'b0;
                    case (r_q.st)
                        ST_POLL_OP: r_d.st = ST_POLL_IN;
                        ST_POLL_IN: begin
                            if (!sh_rx[0]) begin
                                r_d.polls = '0;
                                r_d.ret   = ST_WREN;
                                r_d.st    = ST_TOG_HI;
                            end else if (r_q.polls == PW'(POLL_LIMIT - 1)) begin
                                r_d.cs_n  = 1'b1;
                                r_d.error = 1'b1;
                                r_d.st    = ST_IDLE;
                            end else begin
                                r_d.polls = r_q.polls + 1'b1;
                                r_d.ret   = ST_POLL_OP;
                                r_d.st    = ST_TOG_HI;
                            end
                        end
                        ST_WREN: begin
                            r_d.ret = ST_WR_OP;
                            r_d.st  = ST_TOG_HI;
                        end
                        ST_WR_OP:   r_d.st = ST_WR_ADDR;
                        ST_WR_ADDR: r_d.st = ST_WR_WAIT;
                        default: begin
                            r_d.widx = r_q.widx + 1'b1;
                            r_d.left = r_q.left - 1'b1;
                            if (r_q.left == IDX_W'(1)) begin
                                r_d.cs_n = 1'b1;
                                r_d.tmr  = '0;
                                r_d.st   = ST_SETTLE;
                            end else if ((next_byte % (IDX_W + 1)'(PAGE_BYTES)) == '0) begin
                                r_d.ret = ST_POLL_OP;
                                r_d.st  = ST_TOG_HI;
                            end else begin
                                r_d.st = ST_WR_WAIT;
                            end
                        end
                    endcase
                end
            end
            ST_WR_WAIT: if (wr_valid) begin
                r_d.word = swap_bytes(wr_data);
                r_d.st   = ST_WR_DATA;
            end
            ST_SETTLE: begin
                if (r_q.tmr == TW'(SETTLE_CLKS - 1)) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else r_d.tmr = r_q.tmr + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ret  <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    spiwr_shift #(.HALF_CLKS(HALF_CLKS), .MAX_BITS(SHW), .BW(BW)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (r_q.go),
        .send  (r_q.send),
        .tx    (r_q.tx),
        .nbits (r_q.nbits),
        .miso  (spi_miso),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .fin   (sh_fin),
        .rx    (sh_rx)
    );

    assign wr_ready = (r_q.st == ST_WR_WAIT);
    assign done     = r_q.done;
    assign error    = r_q.error;
    assign spi_cs_n = r_q.cs_n;

    // R9
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    // R10
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);
    // R3
    error_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> spi_cs_n);
    // R11
    ready_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);
    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.st == ST_IDLE && bad_req) |=> (error && spi_cs_n));

endmodule

// File: tb/test_spi_eeprom_writer.sv
module test_spi_eeprom_writer;
    localparam int WORD_SIZE = 256;
    localparam int ADDR_BITS = 8;
    localparam int OP_BITS   = 8;
    localparam int PAGE      = 8;
    localparam int HALF      = 2;
    localparam int PLIM      = 4;
    localparam int SETTLE    = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] first_word = '0, word_count = '0, wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready, done, error, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    spi_eeprom_writer #(
        .WORD_SIZE(WORD_SIZE), .ADDR_BITS(ADDR_BITS), .OP_BITS(OP_BITS),
        .PAGE_BYTES(PAGE), .HALF_CLKS(HALF), .POLL_LIMIT(PLIM),
        .SETTLE_CLKS(SETTLE), .IDX_W(16)
    ) i_spi_eeprom_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .first_word(first_word),
        .word_count(word_count), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .done(done), .error(error), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int           len;
        logic [127:0] bits;
        string        req;
    } frame_t;
    frame_t exp_q[$];

    // device model
    logic [127:0] fbits = '0;
    int           fcnt = 0;
    logic [7:0]   fop = '0;
    int           busy_left = 0;
    int           frames_seen = 0;
    int           sck_bad = 0;
    int           cyc = 0;
    int           cs_rise_cyc = 0;
    logic         cs_prev = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (spi_cs_n && !cs_prev) cs_rise_cyc = cyc;
        cs_prev = spi_cs_n;
    end

    always @(posedge spi_sck) if (spi_cs_n) sck_bad++;

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (fcnt > 0) begin
                frames_seen++;
                if (fop == 8'h05 && fcnt == 16 && busy_left > 0) busy_left--;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected frame", fbits, 128'd0);
                end else begin
                    frame_t f;
                    f = exp_q.pop_front();
                    check(fcnt == f.len, f.req, "frame length", 128'(fcnt), 128'(f.len));
                    check(fbits == f.bits, f.req, "frame bits", fbits, f.bits);
                end
            end
            fcnt  = 0;
            fbits = '0;
            fop   = '0;
        end else begin
            fbits = {fbits[126:0], spi_mosi};
            fcnt++;
            if (fcnt == 8) fop = fbits[7:0];
        end
    end

    always_comb begin
        logic [7:0] stat;
        stat = (busy_left > 0) ? 8'h01 : 8'h00;
        if (fop == 8'h05 && fcnt >= 9 && fcnt <= 16) spi_miso = stat[16 - fcnt];
        else                                         spi_miso = 1'b0;
    end

    function automatic logic [15:0] wval(input int i);
        return 16'((i * 16'h0313) ^ 16'hA5C0);
    endfunction

    int words_sent = 0;

    task automatic feed(input int off, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            repeat (i % 3) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = wval(off + i);
            @(negedge clk);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
            words_sent++;
        end
    endtask

    task automatic push(input int len, input logic [127:0] bits, input string req);
        frame_t f;
        f.len = len; f.bits = bits; f.req = req;
        exp_q.push_back(f);
    endtask

    // driver: predicts frames, runs the request, checks the outcome
    task automatic do_write(input int off, input int cnt, input int busy,
                            input bit tmo, input string req);
        int widx;
        int npoll;
        bit first;
        bit got_done;
        bit got_err;
        int waited;
        busy_left  = busy;
        words_sent = 0;
        if (tmo) begin
            for (int p = 0; p < PLIM; p++) push(16, 128'h0500, "R3");
        end else begin
            widx  = off;
            first = 1'b1;
            while (widx < off + cnt) begin
                logic [127:0] b;
                logic [7:0]   op;
                int           len;
                npoll = first ? busy + 1 : 1;
                first = 1'b0;
                for (int p = 0; p < npoll; p++) push(16, 128'h0500, "R2");
                push(8, 128'h06, "R4");
                op  = (widx >= 128) ? 8'h0A : 8'h02;
                b   = 128'(op);
                b   = (b << 8) | 128'((2 * widx) & 255);
                len = 16;
                do begin
                    logic [15:0] w;
                    w   = wval(widx);
                    b   = (b << 16) | 128'({w[7:0], w[15:8]});
                    len += 16;
                    widx++;
                end while (widx < off + cnt && ((2 * widx) % PAGE) != 0);
                push(len, b, req);
            end
            fork feed(off, cnt); join_none
        end
        @(negedge clk);
        first_word = 16'(off);
        word_count = 16'(cnt);
        start      = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        got_done = 1'b0;
        got_err  = 1'b0;
        waited   = 0;
        while (!got_done && !got_err && waited < 20000) begin
            if (done)  got_done = 1'b1;
            if (error) got_err  = 1'b1;
            if (!got_done && !got_err) @(negedge clk);
            waited++;
        end
        if (tmo) begin
            check(got_err && !got_done, "R3", "timeout error pulse", 128'(got_err), 128'd1);
        end else begin
            check(got_done && !got_err, "R10", "done pulse", 128'(got_done), 128'd1);
            check(cyc - cs_rise_cyc >= SETTLE, "R10", "settle interval",
                  128'(cyc - cs_rise_cyc), 128'(SETTLE));
            check(words_sent == cnt, "R11", "words consumed", 128'(words_sent), 128'(cnt));
        end
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, req, "frames missing", 128'(exp_q.size()), 128'd0);
        check(spi_cs_n == 1'b1, req, "cs high after request", 128'(spi_cs_n), 128'd1);
        exp_q.delete();
        busy_left = 0;
    endtask

    task automatic do_reject(input int off, input int cnt);
        int n0;
        n0 = frames_seen;
        @(negedge clk);
        first_word = 16'(off);
        word_count = 16'(cnt);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(error == 1'b1, "R1", "reject error pulse", 128'(error), 128'd1);
        @(negedge clk);
        check(error == 1'b0, "R1", "error lasts one cycle", 128'(error), 128'd0);
        repeat (30) @(negedge clk);
        check(frames_seen == n0 && spi_cs_n, "R1", "no traffic on reject",
              128'(frames_seen - n0), 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R11 reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R9", "reset cs/sck",
              128'({spi_cs_n, spi_sck}), 128'b10);
        check(!done && !error && !wr_ready, "R11", "reset outputs",
              128'({done, error, wr_ready}), 128'd0);

        do_reject(256, 1);          // R1 index out of range
        do_reject(5, 0);            // R1 zero count
        do_reject(250, 7);          // R1 count past end

        do_write(3, 1, 0, 1'b0, "R7");     // single word, byte swap, R5
        do_write(2, 5, 0, 1'b0, "R8");     // crosses a page boundary
        do_write(130, 2, 0, 1'b0, "R6");   // high half, opcode carries A8
        do_write(9, 2, 2, 1'b0, "R2");     // busy twice then ready
        do_write(20, 3, 10, 1'b1, "R3");   // never ready
        do_write(250, 6, 1, 1'b0, "R5");   // runs to last word

        check(sck_bad == 0, "R9", "sck high while deselected", 128'(sck_bad), 128'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule